// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for a configurable number of pins. The pins are split into banks of 32, and every register kind is repeated once per bank. Software drives a pin high or low by writing ones to write-only set and clear words. It can also write or read the output value directly. Software chooses the pin direction, reads the synchronised pad levels, and selects for each pin either the GPIO path or one of three peripheral lanes.

Each pin can raise an interrupt. A pin is configured either to trigger on any change of its synchronised input or to trigger while that input is high. Detected events latch into a sticky status bit, whether or not the pin is enabled. Software clears a status bit by writing a one to it. An identity word per bank shows the pending pins that are also enabled, and a single registered interrupt line is the OR of every identity bit.

The bus is a simple strobe interface. A read response is controlled by a two-state machine. `RD_IDLE` moves to `RD_RESP` in any cycle where the read strobe is high. `RD_RESP` returns to `RD_IDLE` when no read is issued, and stays in `RD_RESP` when reads come back to back. The read data belongs to the state that held before the strobe's clock edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NB = 1 + (NUM_PINS-1)/32 banks, register kind k of bank b sits at byte address 4*(k*NB + b). A pin p uses bank p/32 and bit p%32. The kind codes are: set 0, clear 1, output value 2, input 3, output enable 4, interrupt status 5, interrupt enable 6, identity 7, function bit 0 at 8, function bit 1 at 9, trigger type 10.
- R2: A one written to a bit of the set word drives that pin's output value to 1, and a one in the clear word drives it to 0. Zero bits in either word change nothing. Both words read as zero.
- R3: The output-value word can be written and read back directly.
- R4: The input word returns the pad levels after a two-flop synchroniser. A read issued three or more cycles after a pad change shows the new level.
- R5: An output-enable bit of 1 makes a GPIO-mode pin an output (pad_oe high), and 0 makes it an input. pad_out of a GPIO-mode pin follows its output-value bit.
- R6: When a pin's trigger-type bit is 0, any change of its synchronised input sets its status bit. The bit is set whatever the enable bit is, and it stays set until software clears it.
- R7: When a pin's trigger-type bit is 1, the status bit is set in every cycle that the synchronised input is high. A clear written while the input is high therefore leaves the bit set.
- R8: A one written to a status bit clears it, and zero bits have no effect. If an event occurs in the same cycle as the clear, the event wins.
- R9: The identity word reads as the bank's status bits ANDed with its enable bits. Writes to it are ignored.
- R10: The irq output is high exactly one cycle after any identity bit, in any bank, is high.
- R11: A pin's function code is {function bit 1, function bit 0}. Code 0 selects the GPIO registers. A code c from 1 to 3 drives pad_out and pad_oe from alt_out and alt_oe bit (c-1)*NUM_PINS + pin.
- R12: Bits for pins at or above NUM_PINS read as zero and ignore writes. Addresses that are not word-aligned, and kind codes above 10, read as zero and ignore writes.
- R13: Reset clears every register, so all pins start as GPIO inputs with irq low. bus_rvalid is high exactly in the cycle after a cycle with bus_rd high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| alt_out | input | 3*NUM_PINS | Peripheral output values, lane-major |
| alt_oe | input | 3*NUM_PINS | Peripheral output enables, lane-major |
| irq | output | 1 | Combined registered interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe. pad_out and pad_oe therefore change just after that edge, and a read issued at a later edge returns the new value one cycle after its strobe. A pad change reaches the input word and the edge detector after two edges and sets a status bit at the third. irq follows the identity word one edge later. The bench drives every input at the falling edge and compares just after each rising edge against a behavioural per-pin model advanced at that edge. The explicit checks wait those counted cycles before sampling.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BANK_W = 32;
    localparam int LAST_KIND = 10;

    typedef enum logic [3:0] {
        K_SET   = 4'd0,
        K_CLR   = 4'd1,
        K_OUT   = 4'd2,
        K_IN    = 4'd3,
        K_OE    = 4'd4,
        K_STAT  = 4'd5,
        K_IEN   = 4'd6,
        K_IDENT = 4'd7,
        K_FN0   = 4'd8,
        K_FN1   = 4'd9,
        K_TRIG  = 4'd10,
        K_NONE  = 4'd15
    } reg_kind_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Lanes of a bank that correspond to existing pins
    function automatic logic [BANK_W-1:0] lane_mask(input int bank, input int npins);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((bank * BANK_W + i) < npins);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
            q_prev <= q;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] in_sync,
    input  logic [BANK_W-1:0] in_prev,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] oe_q,
    output logic [BANK_W-1:0] fn0_q,
    output logic [BANK_W-1:0] fn1_q,
    output logic [BANK_W-1:0] stat_q,
    output logic [BANK_W-1:0] ien_q,
    output logic [BANK_W-1:0] trig_q,
    output logic [BANK_W-1:0] ident
);

    localparam logic [BANK_W-1:0] VALID = lane_mask(BANK_IDX, NUM_PINS);

    logic [BANK_W-1:0] wmask;
    logic [BANK_W-1:0] clr;
    logic [BANK_W-1:0] edge_ev;
    logic [BANK_W-1:0] level_ev;
    logic [BANK_W-1:0] ev;

    assign wmask    = wdata & VALID;
    assign clr      = (wr_en && kind == K_STAT) ? wmask : '0;
    assign edge_ev  = (in_sync ^ in_prev) & ~trig_q;
    assign level_ev = in_sync & trig_q;
    assign ev       = (edge_ev | level_ev) & VALID;

    // Configuration and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            fn0_q  <= '0;
            fn1_q  <= '0;
            ien_q  <= '0;
            trig_q <= '0;
        end else if (wr_en) begin
            case (kind)
                K_SET:   out_q  <= out_q | wmask;
                K_CLR:   out_q  <= out_q & ~wmask;
                K_OUT:   out_q  <= wmask;
                K_OE:    oe_q   <= wmask;
                K_IEN:   ien_q  <= wmask;
                K_FN0:   fn0_q  <= wmask;
                K_FN1:   fn1_q  <= wmask;
                K_TRIG:  trig_q <= wmask;
                default: ;
            endcase
        end
    end

    // Sticky status: new events take priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | ev;
        end
    end

    assign ident = stat_q & ien_q;

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_SET) |=> ((out_q & $past(wmask)) == $past(wmask))); // R2
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_CLR) |=> ((out_q & $past(wmask)) == '0)); // R2
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == K_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
    AST_LEVEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|(trig_q & in_sync & VALID)) |=>
        ((stat_q & $past(trig_q & in_sync & VALID)) == $past(trig_q & in_sync & VALID))); // R7
    AST_GHOST_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_q | oe_q | stat_q | ien_q | fn0_q | fn1_q | trig_q) & ~VALID) == '0); // R12

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NUM_PINS = 32,
    parameter int LANES    = 3
) (
    input  logic [NUM_PINS-1:0]       gpio_out,
    input  logic [NUM_PINS-1:0]       gpio_oe,
    input  logic [NUM_PINS-1:0]       fn0,
    input  logic [NUM_PINS-1:0]       fn1,
    input  logic [LANES*NUM_PINS-1:0] alt_out,
    input  logic [LANES*NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0]       pad_out,
    output logic [NUM_PINS-1:0]       pad_oe
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [1:0] code;
        assign code = {fn1[p], fn0[p]};

        always_comb begin
            if (code == 2'd0) begin
                pad_out[p] = gpio_out[p];
                pad_oe[p]  = gpio_oe[p];
            end else begin
                pad_out[p] = alt_out[(int'(code) - 1) * NUM_PINS + p];
                pad_oe[p]  = alt_oe[(int'(code) - 1) * NUM_PINS + p];
            end
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 40,
    parameter int ADDR_W   = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BANK_W-1:0]     bus_wdata,
    output logic [BANK_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    input  logic [3*NUM_PINS-1:0] alt_out,
    input  logic [3*NUM_PINS-1:0] alt_oe,
    output logic                  irq
);

    localparam int NB   = 1 + (NUM_PINS - 1) / BANK_W;
    localparam int PADW = NB * BANK_W;

    // Input synchroniser and bank-wide extension
    logic [NUM_PINS-1:0] in_s;
    logic [NUM_PINS-1:0] in_p;
    logic [PADW-1:0]     s_ext;
    logic [PADW-1:0]     p_ext;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pad_in),
        .q      (in_s),
        .q_prev (in_p)
    );

    always_comb begin
        s_ext = '0;
        p_ext = '0;
        s_ext[NUM_PINS-1:0] = in_s;
        p_ext[NUM_PINS-1:0] = in_p;
    end

    // Address decode: word = kind * NB + bank
    logic [31:0] word_idx;
    logic [31:0] kind_num;
    logic [31:0] bank_num;
    reg_kind_e   kind;

    assign word_idx = 32'(bus_addr[ADDR_W-1:2]);
    assign kind_num = word_idx / NB;
    assign bank_num = word_idx % NB;

    always_comb begin
        if (bus_addr[1:0] == 2'b00 && kind_num <= 32'(LAST_KIND)) begin
            kind = reg_kind_e'(kind_num[3:0]);
        end else begin
            kind = K_NONE;
        end
    end

    // Bank instances
    logic [BANK_W-1:0] out_b   [NB];
    logic [BANK_W-1:0] oe_b    [NB];
    logic [BANK_W-1:0] fn0_b   [NB];
    logic [BANK_W-1:0] fn1_b   [NB];
    logic [BANK_W-1:0] stat_b  [NB];
    logic [BANK_W-1:0] ien_b   [NB];
    logic [BANK_W-1:0] trig_b  [NB];
    logic [BANK_W-1:0] ident_b [NB];
    logic [NB-1:0]     bank_hit;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_hit[b] = |ident_b[b];

        gpio_bank #(
            .BANK_IDX (b),
            .NUM_PINS (NUM_PINS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && (bank_num == 32'(b)) && (kind != K_NONE)),
            .kind    (kind),
            .wdata   (bus_wdata),
            .in_sync (s_ext[b*BANK_W +: BANK_W]),
            .in_prev (p_ext[b*BANK_W +: BANK_W]),
            .out_q   (out_b[b]),
            .oe_q    (oe_b[b]),
            .fn0_q   (fn0_b[b]),
            .fn1_q   (fn1_b[b]),
            .stat_q  (stat_b[b]),
            .ien_q   (ien_b[b]),
            .trig_q  (trig_b[b]),
            .ident   (ident_b[b])
        );
    end

    // Per-pin views for the pad multiplexer
    logic [NUM_PINS-1:0] gpio_out;
    logic [NUM_PINS-1:0] gpio_oe;
    logic [NUM_PINS-1:0] fn0_all;
    logic [NUM_PINS-1:0] fn1_all;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            gpio_out[p] = out_b[p / BANK_W][p % BANK_W];
            gpio_oe[p]  = oe_b[p / BANK_W][p % BANK_W];
            fn0_all[p]  = fn0_b[p / BANK_W][p % BANK_W];
            fn1_all[p]  = fn1_b[p / BANK_W][p % BANK_W];
        end
    end

    gpio_pad_mux #(
        .NUM_PINS (NUM_PINS),
        .LANES    (3)
    ) u_mux (
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .fn0      (fn0_all),
        .fn1      (fn1_all),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // Read data selection
    logic [BANK_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NB; b++) begin
            if (bank_num == 32'(b)) begin
                case (kind)
                    K_OUT:   rd_word = out_b[b];
                    K_IN:    rd_word = s_ext[b*BANK_W +: BANK_W];
                    K_OE:    rd_word = oe_b[b];
                    K_STAT:  rd_word = stat_b[b];
                    K_IEN:   rd_word = ien_b[b];
                    K_IDENT: rd_word = ident_b[b];
                    K_FN0:   rd_word = fn0_b[b];
                    K_FN1:   rd_word = fn1_b[b];
                    K_TRIG:  rd_word = trig_b[b];
                    default: rd_word = '0;
                endcase
            end
        end
    end

    // Read response state machine
    rd_state_e rd_state_q;
    rd_state_e rd_state_d;

    always_comb begin
        rd_state_d = bus_rd ? RD_RESP : RD_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_state_q <= RD_IDLE;
        end else begin
            rd_state_q <= rd_state_d;
        end
    end

    always_comb begin
        unique case (rd_state_q)
            RD_IDLE: bus_rvalid = 1'b0;
            RD_RESP: bus_rvalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_word;
        end
    end

    // Combined interrupt, registered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |bank_hit;
        end
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R13
    AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R13
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|bank_hit)); // R10

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;

    localparam int NP = 40;
    localparam int NB = 2;
    localparam int AW = 10;

    logic            clk;
    logic            rst_n;
    logic            bus_wr;
    logic            bus_rd;
    logic [AW-1:0]   bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [NP-1:0]   pad_in;
    logic [NP-1:0]   pad_out;
    logic [NP-1:0]   pad_oe;
    logic [3*NP-1:0] alt_out;
    logic [3*NP-1:0] alt_oe;
    logic            irq;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .alt_out    (alt_out),
        .alt_oe     (alt_oe),
        .irq        (irq)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural per-pin reference model
    bit m_out  [NP];
    bit m_oe   [NP];
    bit m_f0   [NP];
    bit m_f1   [NP];
    bit m_ien  [NP];
    bit m_trig [NP];
    bit m_stat [NP];
    bit m_s1   [NP];
    bit m_s2   [NP];
    bit m_s3   [NP];
    bit m_ev   [NP];
    bit m_irq;
    bit exp_rv;
    logic [31:0] exp_rd;

    function automatic int adr(input int k, input int b);
        return 4 * (k * NB + b);
    endfunction

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        logic [31:0] r;
        int w;
        int k;
        int b;
        r = '0;
        w = int'(a) / 4;
        k = w / NB;
        b = w % NB;
        if (a[1:0] == 2'b00) begin
            for (int i = 0; i < 32; i++) begin
                int p;
                p = b * 32 + i;
                if (p < NP) begin
                    case (k)
                        2:  r[i] = m_out[p];
                        3:  r[i] = m_s2[p];
                        4:  r[i] = m_oe[p];
                        5:  r[i] = m_stat[p];
                        6:  r[i] = m_ien[p];
                        7:  r[i] = m_stat[p] & m_ien[p];
                        8:  r[i] = m_f0[p];
                        9:  r[i] = m_f1[p];
                        10: r[i] = m_trig[p];
                        default: r[i] = 1'b0;
                    endcase
                end
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin : model
        bit any_id;
        int w;
        int k;
        int b;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_out[p] = 0; m_oe[p] = 0; m_f0[p] = 0; m_f1[p] = 0;
                m_ien[p] = 0; m_trig[p] = 0; m_stat[p] = 0;
                m_s1[p] = 0; m_s2[p] = 0; m_s3[p] = 0;
            end
            m_irq  = 0;
            exp_rv = 0;
        end else begin
            any_id = 0;
            for (int p = 0; p < NP; p++) begin
                if (m_stat[p] && m_ien[p]) any_id = 1;
                m_ev[p] = m_trig[p] ? m_s2[p] : (m_s2[p] != m_s3[p]);
            end
            exp_rv = bus_rd;
            if (bus_rd) exp_rd = m_read(bus_addr);
            if (bus_wr && bus_addr[1:0] == 2'b00) begin
                w = int'(bus_addr) / 4;
                k = w / NB;
                b = w % NB;
                for (int i = 0; i < 32; i++) begin
                    int p;
                    p = b * 32 + i;
                    if (p < NP) begin
                        case (k)
                            0:  if (bus_wdata[i]) m_out[p] = 1;
                            1:  if (bus_wdata[i]) m_out[p] = 0;
                            2:  m_out[p]  = bus_wdata[i];
                            4:  m_oe[p]   = bus_wdata[i];
                            5:  if (bus_wdata[i]) m_stat[p] = 0;
                            6:  m_ien[p]  = bus_wdata[i];
                            8:  m_f0[p]   = bus_wdata[i];
                            9:  m_f1[p]   = bus_wdata[i];
                            10: m_trig[p] = bus_wdata[i];
                            default: ;
                        endcase
                    end
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (m_ev[p]) m_stat[p] = 1;
                m_s3[p] = m_s2[p];
                m_s2[p] = m_s1[p];
                m_s1[p] = pad_in[p];
            end
            m_irq = any_id;
        end
    end

    // Compare on every clock, just after the rising edge
    always @(posedge clk) begin : compare
        logic [NP-1:0] eo;
        logic [NP-1:0] eoe;
        #1;
        for (int p = 0; p < NP; p++) begin
            int code;
            code = {m_f1[p], m_f0[p]};
            if (code == 0) begin
                eo[p]  = m_out[p];
                eoe[p] = m_oe[p];
            end else begin
                eo[p]  = alt_out[(code - 1) * NP + p];
                eoe[p] = alt_oe[(code - 1) * NP + p];
            end
        end
        chk("R11 pad_out", 64'(pad_out), 64'(eo));
        chk("R5 pad_oe", 64'(pad_oe), 64'(eoe));
        chk("R10 irq", 64'(irq), 64'(m_irq));
        chk("R13 rvalid", 64'(bus_rvalid), 64'(exp_rv));
        if (exp_rv) chk("R1 rdata", 64'(bus_rdata), 64'(exp_rd));
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input int a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(posedge clk);
        #1;
        chk(tag, 64'(bus_rvalid), 64'd1);
        chk(tag, 64'(bus_rdata), 64'(e));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; alt_out = '0; alt_oe = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        rd_expect(adr(4, 0), 32'h0, "R13");
        rd_expect(adr(2, 1), 32'h0, "R13");
        settle();
        chk("R13 pad_oe", 64'(pad_oe), 64'h0);
        chk("R13 irq", 64'(irq), 64'h0);

        // R2: set/clear
        wr(adr(0, 0), 32'h0000_00F0);
        rd_expect(adr(2, 0), 32'h0000_00F0, "R2");
        wr(adr(1, 0), 32'h0000_0030);
        rd_expect(adr(2, 0), 32'h0000_00C0, "R2");
        wr(adr(0, 0), 32'h0);
        wr(adr(1, 0), 32'h0);
        rd_expect(adr(2, 0), 32'h0000_00C0, "R2");
        rd_expect(adr(0, 0), 32'h0, "R2");

        // R3: direct output value
        wr(adr(2, 0), 32'h1234_5678);
        rd_expect(adr(2, 0), 32'h1234_5678, "R3");
        wr(adr(2, 0), 32'h0000_00C0);
        wr(adr(2, 1), 32'hFFFF_FFFF);
        rd_expect(adr(2, 1), 32'h0000_00FF, "R12");

        // R1 / R5: per-bank addressing and direction
        wr(adr(4, 0), 32'h0000_00FF);
        wr(adr(4, 1), 32'h0000_0005);
        rd_expect(adr(4, 0), 32'h0000_00FF, "R1");
        rd_expect(adr(4, 1), 32'h0000_0005, "R1");
        settle();
        chk("R5 pad_oe", 64'(pad_oe), 64'h05_0000_00FF);
        chk("R5 pad_out", 64'(pad_out), 64'hFF_0000_00C0);

        // R4: synchronised input
        @(negedge clk);
        pad_in = 40'h5A_0000_00A5;
        repeat (3) @(negedge clk);
        rd_expect(adr(3, 0), 32'h0000_00A5, "R4");
        rd_expect(adr(3, 1), 32'h0000_005A, "R4");

        // R8: write-one-to-clear
        repeat (3) @(negedge clk);
        wr(adr(5, 0), 32'hFFFF_FFFF);
        wr(adr(5, 1), 32'hFFFF_FFFF);
        rd_expect(adr(5, 0), 32'h0, "R8");
        rd_expect(adr(5, 1), 32'h0, "R8");

        // R6: edge event while masked
        @(negedge clk);
        pad_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd_expect(adr(5, 0), 32'h0000_0008, "R6");
        rd_expect(adr(7, 0), 32'h0, "R9");
        chk("R10 irq masked", 64'(irq), 64'h0);

        // R9 / R10: identity and combined interrupt
        wr(adr(6, 0), 32'h0000_0008);
        rd_expect(adr(7, 0), 32'h0000_0008, "R9");
        chk("R10 irq raised", 64'(irq), 64'h1);
        wr(adr(7, 0), 32'h0);
        rd_expect(adr(7, 0), 32'h0000_0008, "R9");
        wr(adr(5, 0), 32'h0000_0008);
        settle();
        chk("R10 irq dropped", 64'(irq), 64'h0);
        rd_expect(adr(7, 0), 32'h0, "R9");

        // R7: level trigger on pin 32
        wr(adr(10, 1), 32'h0000_0001);
        @(negedge clk);
        pad_in[32] = 1'b1;
        repeat (4) @(negedge clk);
        wr(adr(5, 1), 32'h0000_0001);
        rd_expect(adr(5, 1), 32'h0000_0001, "R7");
        @(negedge clk);
        pad_in[32] = 1'b0;
        repeat (4) @(negedge clk);
        wr(adr(5, 1), 32'h0000_0001);
        rd_expect(adr(5, 1), 32'h0, "R7");

        // R11: peripheral lanes
        @(negedge clk);
        alt_out[0 * NP + 8]  = 1'b1;
        alt_oe[0 * NP + 8]   = 1'b1;
        alt_out[1 * NP + 9]  = 1'b1;
        alt_out[2 * NP + 10] = 1'b1;
        wr(adr(8, 0), 32'h0000_0500);
        wr(adr(9, 0), 32'h0000_0600);
        settle();
        chk("R11 lanes out", 64'(pad_out[10:8]), 64'h7);
        chk("R11 lanes oe", 64'(pad_oe[10:8]), 64'h1);
        @(negedge clk);
        alt_out[2 * NP + 10] = 1'b0;
        settle();
        chk("R11 lane3 follows", 64'(pad_out[10]), 64'h0);
        wr(adr(8, 0), 32'h0);
        wr(adr(9, 0), 32'h0);
        settle();
        chk("R11 back to gpio", 64'(pad_out[10:8]), 64'h0);

        // R12: absent pins, unaligned and unused addresses
        wr(adr(0, 1), 32'hFFFF_FF00);
        rd_expect(adr(2, 1), 32'h0000_00FF, "R12");
        rd_expect(4 * 60, 32'h0, "R12");
        wr(adr(4, 0) + 1, 32'h0);
        rd_expect(adr(4, 0), 32'h0000_00FF, "R12");
        rd_expect(adr(4, 0) + 2, 32'h0, "R12");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule